// File: doc/BRIEF.md
# Bus-master disk DMA channel registers

This block holds the control state that a host processor programs to run one disk DMA channel. It occupies an 8-byte I/O window. A command byte starts and stops the engine and sets the transfer direction. A status byte reports engine progress and keeps the sticky error and completion flags. A 32-bit pointer gives the memory address of the descriptor table that the engine walks. The descriptor fetch and data movement engine lies outside this block. It sees only a start level, a direction level and the table address. It reports back through an active level and two one-cycle event pulses.

The host side is a single-cycle register port. Reads are combinational. Writes take effect at the next clock edge. Byte accesses carry their data in bits 7:0. Dword accesses reach the aligned dword that contains the address: the low dword holds command (bits 7:0) and status (bits 23:16), and the high dword holds the table pointer. Driver software judges a transfer good only when status bits 2:0 read binary 100 (completion set, no error, not active). It then clears the flags by writing ones to them, and leaves the drive capability bits as they were.

Top module: `busmaster_regs`

## Requirements
- R1: After reset, the command byte, the sticky status flags, the capability flags and the table pointer are all zero, and eng_start and irq_out are low.
- R2: A write to the command byte (offset 0) sets eng_start from data bit 0 at the next clock edge. Writing 1 starts the engine and writing 0 stops it.
- R3: Command bit 3 drives eng_dir_to_mem (1 = device to memory, 0 = memory to device). Command bits 1, 2 and 4 to 7 read as zero.
- R4: Status bit 0 (offset 2) always reads the present level of eng_active, and writes to it have no effect.
- R5: An eng_error_pulse sets status bit 1 and an eng_irq_pulse sets status bit 2 at the next edge. Both bits stay set until software clears them.
- R6: Writing 1 to status bit 1 or bit 2 clears that bit, and writing 0 leaves it unchanged.
- R7: When an event pulse and a clearing write to the same status bit arrive in the same cycle, the bit ends up set.
- R8: Status bits 5 and 6 are read/write capability flags for drive 0 and drive 1. They change only on a status write, and status bits 3, 4 and 7 read as zero.
- R9: The table pointer (offsets 4 to 7) accepts a dword write or single-byte writes. It reads back through the port and drives eng_table_base, and its bits 1:0 are always zero.
- R10: irq_out is high exactly while status bit 2 is set.
- R11: Offsets 1 and 3 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_dword | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_addr | input | 3 | Byte offset in the window |
| bus_wdata | input | 32 | Write data (byte data in bits 7:0) |
| bus_rdata | output | 32 | Read data, combinational |
| eng_active | input | 1 | Engine is transferring |
| eng_error_pulse | input | 1 | One-cycle engine error event |
| eng_irq_pulse | input | 1 | One-cycle completion/interrupt event |
| eng_start | output | 1 | Run request to the engine |
| eng_dir_to_mem | output | 1 | Transfer direction, 1 = device to memory |
| eng_table_base | output | 32 | Descriptor table address |
| irq_out | output | 1 | Level interrupt to the host |

## Verification
The assertions check on every cycle that command writes reach eng_start and eng_dir_to_mem one edge later, that event pulses always leave their flag set (even against a clearing write), that a clearing write without a pulse empties the error flag, and that the capability flags hold without a status write. Only the bench scenarios show the read-back paths: live reporting of the active bit, the zero bits, the vendor offsets, byte-wise pointer assembly, and whole random mixes of accesses and events compared against a reference model.

// File: rtl/busmaster_regs.sv
module busmaster_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_dword,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        eng_active,
  input  logic        eng_error_pulse,
  input  logic        eng_irq_pulse,
  output logic        eng_start,
  output logic        eng_dir_to_mem,
  output logic [31:0] eng_table_base,
  output logic        irq_out
);

  logic        run_q, dir_q, err_q, irq_q, cap0_q, cap1_q;
  logic [31:0] ptr_q;

  wire wr_any = bus_sel & bus_wr;
  wire wr_lo  = wr_any & ~bus_addr[2];
  wire wr_hi  = wr_any &  bus_addr[2];
  wire wr_cmd = wr_lo & (bus_dword | (bus_addr[1:0] == 2'd0));
  wire wr_st  = wr_lo & (bus_dword | (bus_addr[1:0] == 2'd2));
  wire [7:0] st_d = bus_dword ? bus_wdata[23:16] : bus_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      dir_q <= 1'b0;
    end else if (wr_cmd) begin
      run_q <= bus_wdata[0];
      dir_q <= bus_wdata[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
      cap0_q <= 1'b0;
      cap1_q <= 1'b0;
    end else begin
      if (eng_error_pulse)        err_q <= 1'b1;
      else if (wr_st && st_d[1])  err_q <= 1'b0;
      if (eng_irq_pulse)          irq_q <= 1'b1;
      else if (wr_st && st_d[2])  irq_q <= 1'b0;
      if (wr_st) begin
        cap0_q <= st_d[5];
        cap1_q <= st_d[6];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      for (int k = 0; k < 4; k++)
        if (wr_hi && (bus_dword || bus_addr[1:0] == k[1:0]))
          ptr_q[8*k +: 8] <= bus_dword ? bus_wdata[8*k +: 8] : bus_wdata[7:0];
      ptr_q[1:0] <= 2'b00;
    end
  end

  wire [7:0]  cmd_b  = {4'b0, dir_q, 2'b0, run_q};
  wire [7:0]  stat_b = {1'b0, cap1_q, cap0_q, 2'b0, irq_q, err_q, eng_active};
  wire [31:0] lo_dw  = {8'h00, stat_b, 8'h00, cmd_b};
  wire [31:0] sel_dw = bus_addr[2] ? ptr_q : lo_dw;

  assign bus_rdata      = bus_dword ? sel_dw : {24'h0, sel_dw[8*bus_addr[1:0] +: 8]};
  assign eng_start      = run_q;
  assign eng_dir_to_mem = dir_q;
  assign eng_table_base = ptr_q;
  assign irq_out        = irq_q;

endmodule

// File: rtl/busmaster_regs_sva.sv
module busmaster_regs_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic        bus_dword,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        eng_error_pulse,
  input logic        eng_irq_pulse,
  input logic        eng_start,
  input logic        eng_dir_to_mem,
  input logic        irq_out,
  input logic        err_q,
  input logic        cap0_q,
  input logic        cap1_q
);
  logic cmd_hit, st_hit;
  logic [7:0] sd;
  assign cmd_hit = bus_sel && bus_wr && !bus_addr[2] && (bus_dword || bus_addr[1:0] == 2'd0);
  assign st_hit  = bus_sel && bus_wr && !bus_addr[2] && (bus_dword || bus_addr[1:0] == 2'd2);
  assign sd      = bus_dword ? bus_wdata[23:16] : bus_wdata[7:0];

  a_r2_start_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> eng_start == $past(bus_wdata[0]));
  a_r3_dir_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> eng_dir_to_mem == $past(bus_wdata[3]));
  a_r5_error_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
    eng_error_pulse |=> err_q);
  a_r7_irq_pulse_wins: assert property (@(posedge clk) disable iff (!rst_n)
    eng_irq_pulse |=> irq_out);
  a_r6_error_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (st_hit && sd[1] && !eng_error_pulse) |=> !err_q);
  a_r8_caps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !st_hit |=> ($stable(cap0_q) && $stable(cap1_q)));
endmodule

bind busmaster_regs busmaster_regs_sva u_sva (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_dword(bus_dword), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .eng_error_pulse(eng_error_pulse), .eng_irq_pulse(eng_irq_pulse),
  .eng_start(eng_start), .eng_dir_to_mem(eng_dir_to_mem), .irq_out(irq_out),
  .err_q(err_q), .cap0_q(cap0_q), .cap1_q(cap1_q)
);

// File: tb/busmaster_regs_test.sv
module busmaster_regs_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, bus_dword = 0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic eng_active = 0, eng_error_pulse = 0, eng_irq_pulse = 0;
  logic eng_start, eng_dir_to_mem, irq_out;
  logic [31:0] eng_table_base;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  busmaster_regs uut (.*);

  bit m_run, m_dir, m_err, m_irq, m_c0, m_c1;
  logic [31:0] m_ptr;

  function automatic logic [31:0] exp_read(logic [2:0] a, bit dw);
    logic [31:0] lo, s;
    lo = {8'h00, {1'b0, m_c1, m_c0, 2'b0, m_irq, m_err, eng_active}, 8'h00, {4'b0, m_dir, 2'b0, m_run}};
    s = a[2] ? m_ptr : lo;
    return dw ? s : {24'h0, s[8*a[1:0] +: 8]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit sel, bit wr, bit dw, logic [2:0] a, logic [31:0] wd,
                      bit act, bit ep, bit ip);
    bit wlo, wst;
    logic [7:0] sd;
    bus_sel = sel; bus_wr = wr; bus_dword = dw; bus_addr = a; bus_wdata = wd;
    eng_active = act; eng_error_pulse = ep; eng_irq_pulse = ip;
    #1;
    if (sel && !wr) chk(tag, bus_rdata, exp_read(a, dw));
    wlo = sel && wr && !a[2];
    wst = wlo && (dw || a[1:0] == 2'd2);
    sd = dw ? wd[23:16] : wd[7:0];
    if (wlo && (dw || a[1:0] == 2'd0)) begin m_run = wd[0]; m_dir = wd[3]; end
    if (ep) m_err = 1; else if (wst && sd[1]) m_err = 0;
    if (ip) m_irq = 1; else if (wst && sd[2]) m_irq = 0;
    if (wst) begin m_c0 = sd[5]; m_c1 = sd[6]; end
    if (sel && wr && a[2])
      for (int k = 0; k < 4; k++)
        if (dw || a[1:0] == k[1:0]) m_ptr[8*k +: 8] = dw ? wd[8*k +: 8] : wd[7:0];
    m_ptr[1:0] = 2'b00;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; eng_error_pulse = 0; eng_irq_pulse = 0;
    chk("R2", eng_start, m_run);
    chk("R3", eng_dir_to_mem, m_dir);
    chk("R9", eng_table_base, m_ptr);
    chk("R10", irq_out, m_irq);
  endtask

  task automatic rd(string tag, logic [2:0] a, bit dw, bit act);
    step(tag, 1, 0, dw, a, 32'h0, act, 0, 0);
  endtask

  function automatic string tag_of(logic [2:0] a);
    if (a[2]) return "R9";
    case (a[1:0])
      2'd0: return "R3";
      2'd2: return "R8";
      default: return "R11";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit r;
    logic [31:0] v;
    v = $urandom(32'h1d3a);
    {m_run, m_dir, m_err, m_irq, m_c0, m_c1} = '0;
    m_ptr = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {eng_start, irq_out}, 2'b00);
    chk("R1", eng_table_base, 32'h0);
    rst_n = 1;
    @(negedge clk);
    rd("R1", 3'd0, 1, 0);
    rd("R1", 3'd4, 1, 0);
    // R2 / R3: start, stop, direction, zero bits
    step("R2", 1, 1, 0, 3'd0, 32'h0000_00ff, 0, 0, 0);
    rd("R3", 3'd0, 0, 0);
    chk("R3", bus_rdata, 32'h09);
    step("R2", 1, 1, 0, 3'd0, 32'h0000_0008, 0, 0, 0);
    chk("R2", eng_start, 0);
    chk("R3", eng_dir_to_mem, 1);
    // R4: active bit live and read-only
    rd("R4", 3'd2, 0, 1);
    step("R4", 1, 1, 0, 3'd2, 32'h0000_0001, 0, 0, 0);
    rd("R4", 3'd2, 0, 0);
    chk("R4", bus_rdata[0], 0);
    // R5 / R10: events set sticky flags
    step("R5", 0, 0, 0, 3'd0, 0, 1, 1, 0);
    step("R5", 0, 0, 0, 3'd0, 0, 0, 0, 1);
    chk("R10", irq_out, 1);
    rd("R5", 3'd2, 0, 0);
    chk("R5", bus_rdata[2:0], 3'b110);
    // R6: write 0 keeps, write 1 clears; success pattern 100
    step("R6", 1, 1, 0, 3'd2, 32'h0000_0000, 0, 0, 0);
    rd("R6", 3'd2, 0, 0);
    chk("R6", bus_rdata[2:0], 3'b110);
    step("R6", 1, 1, 0, 3'd2, 32'h0000_0002, 0, 0, 0);
    rd("R6", 3'd2, 0, 0);
    chk("R6", bus_rdata[2:0], 3'b100);
    step("R6", 1, 1, 0, 3'd2, 32'h0000_0004, 0, 0, 0);
    chk("R10", irq_out, 0);
    // R7: set wins over same-cycle clear
    step("R7", 1, 1, 0, 3'd2, 32'h0000_0006, 0, 1, 1);
    rd("R7", 3'd2, 0, 0);
    chk("R7", bus_rdata[2:1], 2'b11);
    // R8: capability flags, zero bits, preserved across clearing write
    step("R8", 1, 1, 0, 3'd2, 32'h0000_00f8, 0, 0, 0);
    rd("R8", 3'd2, 0, 0);
    chk("R8", bus_rdata[7:3], 5'b01100);
    step("R8", 1, 1, 1, 3'd0, 32'h0066_0000, 0, 0, 0);
    rd("R8", 3'd2, 0, 0);
    chk("R8", bus_rdata, 32'h60);
    // R9: pointer dword and byte writes
    step("R9", 1, 1, 1, 3'd4, 32'hdead_beef, 0, 0, 0);
    chk("R9", eng_table_base, 32'hdead_beec);
    step("R9", 1, 1, 0, 3'd6, 32'h0000_0012, 0, 0, 0);
    rd("R9", 3'd4, 1, 0);
    chk("R9", bus_rdata, 32'hde12_beec);
    step("R9", 1, 1, 0, 3'd4, 32'h0000_0003, 0, 0, 0);
    chk("R9", eng_table_base[7:0], 8'h00);
    // R11: vendor offsets
    step("R11", 1, 1, 0, 3'd1, 32'h0000_00ff, 0, 0, 0);
    step("R11", 1, 1, 0, 3'd3, 32'h0000_00ff, 0, 0, 0);
    rd("R11", 3'd1, 0, 0);
    rd("R11", 3'd3, 0, 0);
    chk("R11", bus_rdata, 32'h0);
    rd("R11", 3'd0, 1, 0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0] a;
      bit dw;
      a = 3'($urandom_range(0, 7));
      dw = ($urandom_range(0, 3) == 0);
      r = $urandom_range(0, 1);
      step(tag_of(a), $urandom_range(0, 2) != 0, r, dw, a, $urandom,
           $urandom_range(0, 1), $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule